// File: doc/BRIEF.md
# Iterative Shift-Add Integer Multiplier

This block multiplies two 32-bit integers over a fixed number of clock cycles, using one adder of operand width instead of a full array. A single 64-bit working register carries both the partially formed product (upper half) and the not-yet-consumed multiplier bits (lower half). On every step the least significant bit of that register decides whether the multiplicand is added into the upper half, and then the whole register, including the adder's carry, moves right by one place.

A caller presents both operands and a mode select, and pulses `start` while the block is idle. The block raises `busy`, runs one step per cycle for 32 cycles, spends one more cycle fixing the sign of the result, and then emits a one-cycle `done` pulse with the upper product word on `prod_hi` and the lower word on `prod_lo`. In signed mode the operands are reduced to magnitudes, multiplied as unsigned numbers, and the 64-bit result is negated when exactly one operand was negative.

Top module: `iter_mult`

## Requirements
- R1: With `mode_signed` = 0, after completion `{prod_hi, prod_lo}` equals the unsigned 64-bit product of `opnd_a` and `opnd_b`.
- R2: With `mode_signed` = 1, after completion `{prod_hi, prod_lo}` equals the two's-complement 64-bit product of the operands for every combination of operand signs.
- R3: In signed mode an operand of 0x80000000 is handled as -2^31, including the case where both operands have that value (result 0x4000000000000000).
- R4: No carry is lost in unsigned mode: 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE00000001.
- R5: `busy` is 1 from the clock edge that accepts `start` until the edge that raises `done`, and `done` rises exactly 33 clock edges after the accepting edge.
- R6: `done` is high for exactly one cycle per operation.
- R7: A `start` pulse arriving while `busy` is 1 is ignored: the running operation keeps its operands and finishes at its original time.
- R8: `prod_hi` and `prod_lo` change only at the edge that raises `done`; they keep the previous result while idle and during the next operation.
- R9: After reset `busy`, `done`, `prod_hi` and `prod_lo` are all 0.
- R10: A zero operand gives an all-zero result in both modes, whatever the sign of the other operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiplication; taken only while idle |
| mode_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| opnd_a | input | 32 | Multiplicand |
| opnd_b | input | 32 | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prod_hi | output | 32 | Upper word of the 64-bit product |
| prod_lo | output | 32 | Lower word of the 64-bit product |

## Verification
The hardest state to reach is a collision between a new `start` and an operation already in flight, because the block only shows the damage 30 cycles later as a wrong result or a shifted `done`. The bench launches one operation, pulses `start` with different operands and mode several cycles into it, and then checks both the finishing cycle and the product of the first operation. Carry retention and the most-negative operand are reached with directed operands (all ones, 0x80000000 pairs) inside the vector table.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } mul_state_t;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  mul_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    step    = 1'b0;
    finish  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          cnt_d   = '0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step  = 1'b1;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIX;
      end
      ST_FIX: begin
        finish  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

  // R5: a run that has not reached its last step keeps running
  a_r5_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q != LAST) |=> (state_q == ST_RUN));

  // R5: the last step is always followed by the sign-fix cycle
  a_r5_fix_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q == LAST) |=> (state_q == ST_FIX && !load));
endmodule

// File: rtl/mul_operand_prep.sv
module mul_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic             is_signed,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_mag,
  output logic [WIDTH-1:0] b_mag,
  output logic             negate
);
  logic a_neg, b_neg;

  always_comb begin
    a_neg  = is_signed & a_in[WIDTH-1];
    b_neg  = is_signed & b_in[WIDTH-1];
    a_mag  = a_neg ? (~a_in + 1'b1) : a_in;
    b_mag  = b_neg ? (~b_in + 1'b1) : b_in;
    negate = a_neg ^ b_neg;
  end

  // R3: a magnitude is never larger than 2^(WIDTH-1) in signed mode
  always_comb begin
    if (is_signed && a_mag[WIDTH-1])
      a_r3_mag_bound: assert (a_mag[WIDTH-2:0] == '0);
  end
endmodule

// File: rtl/mul_accum.sv
module mul_accum #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   mcand_in,
  input  logic [WIDTH-1:0]   mplier_in,
  output logic [2*WIDTH-1:0] prod
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q, mcand_d;
  logic [PW-1:0]    prod_q, prod_d;
  logic [WIDTH:0]   upper_sum;

  always_comb begin
    if (prod_q[0])
      upper_sum = {1'b0, prod_q[PW-1:WIDTH]} + {1'b0, mcand_q};
    else
      upper_sum = {1'b0, prod_q[PW-1:WIDTH]};
  end

  always_comb begin
    mcand_d = mcand_q;
    prod_d  = prod_q;
    if (load) begin
      mcand_d = mcand_in;
      prod_d  = {{WIDTH{1'b0}}, mplier_in};
    end else if (step) begin
      prod_d = {upper_sum, prod_q[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else begin
      if (load) mcand_q <= mcand_d;
      if (load || step) prod_q <= prod_d;
    end
  end

  assign prod = prod_q;

  // R1: a load clears the upper half and seats the multiplier in the lower half
  a_r1_load_seats: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (prod_q[PW-1:WIDTH] == '0 && prod_q[WIDTH-1:0] == $past(mplier_in)));

  // R1: every step moves the consumed lower bits one place right
  a_r1_step_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (prod_q[WIDTH-2:0] == $past(prod_q[WIDTH-1:1])));

  // R4: the multiplicand stays fixed throughout a run
  a_r4_mcand_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> $stable(mcand_q));
endmodule

// File: rtl/mul_result.sv
module mul_result #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               negate_in,
  input  logic               capture,
  input  logic [2*WIDTH-1:0] prod,
  output logic [WIDTH-1:0]   res_hi,
  output logic [WIDTH-1:0]   res_lo,
  output logic               done
);
  localparam int PW = 2 * WIDTH;

  logic          neg_q;
  logic [PW-1:0] fixed;

  always_comb begin
    fixed = neg_q ? (~prod + 1'b1) : prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q  <= 1'b0;
      res_hi <= '0;
      res_lo <= '0;
      done   <= 1'b0;
    end else begin
      if (load) neg_q <= negate_in;
      if (capture) begin
        res_hi <= fixed[PW-1:WIDTH];
        res_lo <= fixed[WIDTH-1:0];
      end
      done <= capture;
    end
  end

  // R6: the completion pulse never lasts two cycles
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: a zero unsigned product stays zero after sign correction
  a_r10_zero_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && prod == '0) |=> (res_hi == '0 && res_lo == '0));
endmodule

// File: rtl/iter_mult.sv
module iter_mult #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_signed,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prod_hi,
  output logic [WIDTH-1:0] prod_lo
);
  localparam int PW = 2 * WIDTH;

  logic             load, step, finish, negate;
  logic [WIDTH-1:0] a_mag, b_mag;
  logic [PW-1:0]    prod;

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .step(step), .finish(finish), .busy(busy)
  );

  mul_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .is_signed(mode_signed), .a_in(opnd_a), .b_in(opnd_b),
    .a_mag(a_mag), .b_mag(b_mag), .negate(negate)
  );

  mul_accum #(.WIDTH(WIDTH)) u_accum (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .mcand_in(a_mag), .mplier_in(b_mag), .prod(prod)
  );

  mul_result #(.WIDTH(WIDTH)) u_result (
    .clk(clk), .rst_n(rst_n), .load(load), .negate_in(negate),
    .capture(finish), .prod(prod),
    .res_hi(prod_hi), .res_lo(prod_lo), .done(done)
  );

  // R7: a start seen mid-run does not end or restart the run
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !finish) |=> busy);

  // R8: results hold while nothing completes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> ($stable(prod_hi) && $stable(prod_lo)));

  // R5: done only follows a busy period
  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
endmodule

// File: tb/iter_mult_bench.sv
module iter_mult_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        mode_signed;
  logic [31:0] opnd_a, opnd_b;
  logic        busy, done;
  logic [31:0] prod_hi, prod_lo;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  iter_mult u_iter_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_signed(mode_signed),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy), .done(done),
    .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  // {signed, a, b}
  localparam logic [64:0] VECS [14] = '{
    {1'b0, 32'h0000_0003, 32'h0000_0005},
    {1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b0, 32'h8000_0000, 32'h0000_0002},
    {1'b0, 32'h1234_5678, 32'h9ABC_DEF0},
    {1'b0, 32'h0000_0000, 32'hDEAD_BEEF},
    {1'b1, 32'hFFFF_FFF9, 32'hFFFF_FFF9},
    {1'b1, 32'hFFFF_FFFC, 32'h3B9A_CA00},
    {1'b1, 32'h0000_0007, 32'hFFFF_FFFE},
    {1'b1, 32'h8000_0000, 32'h8000_0000},
    {1'b1, 32'h8000_0000, 32'h0000_0001},
    {1'b1, 32'h7FFF_FFFF, 32'h8000_0000},
    {1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b1, 32'h0000_0000, 32'h8000_0000},
    {1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF}
  };

  function automatic logic [63:0] model(input logic s, input logic [31:0] a,
                                        input logic [31:0] b);
    logic signed [63:0] sa, sb;
    if (s) begin
      sa = {{32{a[31]}}, a};
      sb = {{32{b[31]}}, b};
      return 64'(sa * sb);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // starts an operation; returns edges from acceptance to done
  task automatic run_op(input logic s, input logic [31:0] a, input logic [31:0] b,
                        output int lat);
    @(negedge clk);
    mode_signed = s; opnd_a = a; opnd_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    check("R5 busy after accept", 64'(busy), 64'd1);
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic [63:0] old;
    rst_n = 1'b0; start = 1'b0; mode_signed = 1'b0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busy/done", {62'b0, busy, done}, 64'd0);
    check("R9 result", {prod_hi, prod_lo}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 14; i++) begin
      run_op(VECS[i][64], VECS[i][63:32], VECS[i][31:0], lat);
      check(VECS[i][64] ? "R2/R3/R10 signed product" : "R1/R4/R10 unsigned product",
            {prod_hi, prod_lo}, model(VECS[i][64], VECS[i][63:32], VECS[i][31:0]));
      check("R5 latency", 64'(lat), 64'd33);
      @(negedge clk);
      check("R6 done pulse width", 64'(done), 64'd0);
    end

    for (int i = 0; i < 10; i++) begin
      logic [31:0] ra, rb;
      logic rs;
      ra = $urandom; rb = $urandom; rs = 1'(i % 2);
      run_op(rs, ra, rb, lat);
      check("R1/R2 random product", {prod_hi, prod_lo}, model(rs, ra, rb));
    end

    // R8: idle hold with changing inputs
    old = {prod_hi, prod_lo};
    @(negedge clk);
    opnd_a = 32'h5555_5555; opnd_b = 32'hAAAA_AAAA; mode_signed = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 idle hold", {prod_hi, prod_lo}, old);

    // R7: start while busy ignored; R8: hold during the next run
    @(negedge clk);
    mode_signed = 1'b0; opnd_a = 32'd1000; opnd_b = 32'd77; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 hold during run", {prod_hi, prod_lo}, old);
    mode_signed = 1'b1; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h0000_0009; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 5;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R7 finish time unchanged", 64'(lat), 64'd33);
    check("R7 first operands kept", {prod_hi, prod_lo}, 64'd77000);
    @(negedge clk);
    check("R7 no restart", {62'b0, busy, done}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule